// File: doc/BRIEF.md
# Deferred System Clock Source Selector

This block chooses which of several clock sources drives the system clock. The sources are an internal RC oscillator, an external oscillator and a PLL. Each source has an enable bit that software sets, and a ready input from the oscillator model. Each ready input passes through a short synchronizer and is then gated by the source's enable. Software writes a requested source code. The selector moves to that source only once the source reports ready. Until then the request waits and is carried out without further software action.

Any source that drives the system clock cannot be switched off, and neither can the reference of the PLL while the PLL is in use. Software writes to the enable vector, and the bits of sources in use are forced to stay set. Each source raises a sticky interrupt flag when its ready goes high, if that source's interrupt enable is set. Software clears a flag by pulsing a per-source clear bit.

The clock mux itself is represented by the registered current-source code. It does not model clock cells.

Top module: `sysclk_src_sel`

## Requirements
- R1: After reset, `sel_cur` and `sel_req` are 0 (internal RC), `src_en` has only bit 0 set, and `irq_flag` is all zero.
- R2: The source codes are 0 for internal RC (enable bit 0), 1 for the external oscillator (bit 1) and 2 for the PLL (bit 2). A write of code 3 leaves `sel_req` unchanged.
- R3: `sel_cur` only changes to a source whose `src_rdy` bit was high in the cycle before the change.
- R4: While a request is pending, `sel_cur` takes the requested code at the first clock edge at which that source's `src_rdy` is high.
- R5: A new valid write to the select replaces an earlier request that is still pending. The earlier source is never selected.
- R6: An enable write cannot clear the enable bit of the source that `sel_cur` names. Enable bits of sources not in use take the written value.
- R7: While the PLL is the current source, its reference (the external oscillator, bit 1) is also protected from being disabled.
- R8: A `src_rdy` bit rises exactly RDY_SYNC clock edges after its ready input goes high. It is never high while that source's enable is low.
- R9: A rising `src_rdy` bit whose `irq_en` bit is set sets the matching `irq_flag` bit, which then stays set. `irq` is high whenever any flag is set.
- R10: A one in `irq_clr` clears the matching flag at the next edge.
- R11: A select write that names a source already ready updates `sel_req` and `sel_cur` at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_wr | input | 1 | Write strobe for the enable vector |
| en_wdata | input | NUM_SRC | Requested enable per source |
| osc_rdy_in | input | NUM_SRC | Raw ready indication from each oscillator |
| sel_wr | input | 1 | Write strobe for the requested source |
| sel_wdata | input | SEL_W | Requested source code |
| irq_en | input | NUM_SRC | Per-source ready interrupt enable |
| irq_clr | input | NUM_SRC | Per-source write-one-to-clear of the flag |
| src_en | output | NUM_SRC | Effective enable of each source |
| src_rdy | output | NUM_SRC | Synchronized, enable-gated ready status |
| sel_req | output | SEL_W | Requested source code |
| sel_cur | output | SEL_W | Source currently driving the system clock |
| irq_flag | output | NUM_SRC | Sticky ready interrupt flags |
| irq | output | 1 | OR of all flags |

## Verification
A stuck pending request shows at the ports as `sel_cur` differing from `sel_req` one edge after the target's `src_rdy` is high. An early switch shows as `sel_cur` moving to a code whose ready bit was low. A broken protection mask shows in the cycle after an enable write, as a cleared bit for the source in use or for the PLL reference. Synchronizer depth errors change the count of edges from ready input to `src_rdy`, and that count is measured directly. A lost edge detector leaves `irq_flag` clear one edge after that rise.

// File: rtl/sysclk_sel_pkg.sv
package sysclk_sel_pkg;
   localparam int SRC_RC  = 0;
   localparam int SRC_XO  = 1;
   localparam int SRC_PLL = 2;
endpackage

// File: rtl/ssel_rdy_sync.sv
module ssel_rdy_sync #(
   parameter int NUM_SRC = 3,
   parameter int STAGES  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] d_in,
   output logic [NUM_SRC-1:0] d_out
);
   if (STAGES == 0) begin : g_pass
      assign d_out = d_in;
   end else begin : g_chain
      logic [STAGES-1:0][NUM_SRC-1:0] chain_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
               chain_q[s] <= chain_q[s-1];
            end
         end
      end
      assign d_out = chain_q[STAGES-1];
   end
endmodule

// File: rtl/ssel_en_guard.sv
module ssel_en_guard #(
   parameter int NUM_SRC = 3,
   parameter int RST_IDX = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_wdata,
   input  logic [NUM_SRC-1:0] in_use,
   output logic [NUM_SRC-1:0] en_q
);
   localparam logic [NUM_SRC-1:0] RST_MASK = NUM_SRC'(1) << RST_IDX;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q <= RST_MASK;
      end else if (en_wr) begin
         en_q <= en_wdata | in_use;
      end
   end
endmodule

// File: rtl/ssel_switch.sv
module ssel_switch #(
   parameter int NUM_SRC = 3,
   parameter int SEL_W   = 2,
   parameter int RST_IDX = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_wr,
   input  logic [SEL_W-1:0]   sel_wdata,
   input  logic [NUM_SRC-1:0] rdy,
   output logic [SEL_W-1:0]   req_q,
   output logic [SEL_W-1:0]   cur_q,
   output logic [SEL_W-1:0]   next_req,
   output logic               do_switch
);
   logic wr_valid;

   assign wr_valid  = sel_wr && (int'(sel_wdata) < NUM_SRC);
   assign next_req  = wr_valid ? sel_wdata : req_q;
   assign do_switch = (next_req != cur_q) && rdy[next_req];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q <= SEL_W'(RST_IDX);
         cur_q <= SEL_W'(RST_IDX);
      end else begin
         req_q <= next_req;
         if (do_switch) begin
            cur_q <= next_req;
         end
      end
   end
endmodule

// File: rtl/ssel_rdy_irq.sv
module ssel_rdy_irq #(
   parameter int NUM_SRC = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] rdy,
   input  logic [NUM_SRC-1:0] irq_en,
   input  logic [NUM_SRC-1:0] irq_clr,
   output logic [NUM_SRC-1:0] flag_q
);
   logic [NUM_SRC-1:0] rdy_prev_q;
   logic [NUM_SRC-1:0] rise;

   assign rise = rdy & ~rdy_prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_prev_q <= '0;
         flag_q     <= '0;
      end else begin
         rdy_prev_q <= rdy;
         flag_q     <= (flag_q & ~irq_clr) | (rise & irq_en);
      end
   end
endmodule

// File: rtl/sysclk_src_sel.sv
module sysclk_src_sel #(
   parameter int NUM_SRC     = 3,
   parameter int SEL_W       = 2,
   parameter int RDY_SYNC    = 2,
   parameter int PLL_IDX     = sysclk_sel_pkg::SRC_PLL,
   parameter int PLL_REF_IDX = sysclk_sel_pkg::SRC_XO
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_wr,
   input  logic [NUM_SRC-1:0] en_wdata,
   input  logic [NUM_SRC-1:0] osc_rdy_in,
   input  logic               sel_wr,
   input  logic [SEL_W-1:0]   sel_wdata,
   input  logic [NUM_SRC-1:0] irq_en,
   input  logic [NUM_SRC-1:0] irq_clr,
   output logic [NUM_SRC-1:0] src_en,
   output logic [NUM_SRC-1:0] src_rdy,
   output logic [SEL_W-1:0]   sel_req,
   output logic [SEL_W-1:0]   sel_cur,
   output logic [NUM_SRC-1:0] irq_flag,
   output logic               irq
);
   localparam int RST_IDX = sysclk_sel_pkg::SRC_RC;

   if (NUM_SRC >= (2 ** SEL_W)) begin : g_bad_width
      $error("SEL_W too narrow for NUM_SRC plus a reserved code");
   end
   if (PLL_IDX >= NUM_SRC || PLL_REF_IDX >= NUM_SRC || PLL_IDX == PLL_REF_IDX) begin : g_bad_pll
      $error("PLL index or its reference index out of range");
   end
   if (RDY_SYNC < 0 || RDY_SYNC > 4) begin : g_bad_sync
      $error("RDY_SYNC must be 0 to 4");
   end

   logic [NUM_SRC-1:0] rdy_sync;
   logic [NUM_SRC-1:0] in_use;
   logic [SEL_W-1:0]   next_req;
   logic               do_switch;

   ssel_rdy_sync #(.NUM_SRC(NUM_SRC), .STAGES(RDY_SYNC)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (osc_rdy_in),
      .d_out (rdy_sync)
   );

   assign src_rdy = rdy_sync & src_en;

   ssel_switch #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .RST_IDX(RST_IDX)) u_switch (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_wr    (sel_wr),
      .sel_wdata (sel_wdata),
      .rdy       (src_rdy),
      .req_q     (sel_req),
      .cur_q     (sel_cur),
      .next_req  (next_req),
      .do_switch (do_switch)
   );

   always_comb begin
      in_use = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (sel_cur == SEL_W'(i) || (do_switch && next_req == SEL_W'(i))) begin
            in_use[i] = 1'b1;
         end
      end
      if (in_use[PLL_IDX]) begin
         in_use[PLL_REF_IDX] = 1'b1;
      end
   end

   ssel_en_guard #(.NUM_SRC(NUM_SRC), .RST_IDX(RST_IDX)) u_guard (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr    (en_wr),
      .en_wdata (en_wdata),
      .in_use   (in_use),
      .en_q     (src_en)
   );

   ssel_rdy_irq #(.NUM_SRC(NUM_SRC)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .rdy     (src_rdy),
      .irq_en  (irq_en),
      .irq_clr (irq_clr),
      .flag_q  (irq_flag)
   );

   assign irq = |irq_flag;
endmodule

// File: rtl/sysclk_src_sel_chk.sv
module sysclk_src_sel_chk #(
   parameter int NUM_SRC     = 3,
   parameter int SEL_W       = 2,
   parameter int PLL_IDX     = 2,
   parameter int PLL_REF_IDX = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sel_wr,
   input logic [SEL_W-1:0]   sel_wdata,
   input logic [NUM_SRC-1:0] irq_clr,
   input logic [NUM_SRC-1:0] src_en,
   input logic [NUM_SRC-1:0] src_rdy,
   input logic [SEL_W-1:0]   sel_req,
   input logic [SEL_W-1:0]   sel_cur,
   input logic [NUM_SRC-1:0] irq_flag
);
   logic [NUM_SRC-1:0] rdy_q;
   logic [SEL_W-1:0]   cur_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_q <= '0;
         cur_q <= '0;
      end else begin
         rdy_q <= src_rdy;
         cur_q <= sel_cur;
      end
   end

   p_switch_to_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_cur != cur_q) |-> rdy_q[sel_cur]);

   p_pending_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel_wr && sel_req != sel_cur && src_rdy[sel_req]) |=> (sel_cur == $past(sel_req)));

   p_cur_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      src_en[sel_cur]);

   p_pll_ref_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel_cur) == PLL_IDX) |-> src_en[PLL_REF_IDX]);

   p_rdy_needs_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_rdy & ~src_en) == '0));

   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(irq_flag & ~irq_clr)) |=> ((irq_flag & $past(irq_flag & ~irq_clr)) == $past(irq_flag & ~irq_clr)));

   p_reserved_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_wr && int'(sel_wdata) >= NUM_SRC) |=> (sel_req == $past(sel_req)));
endmodule

bind sysclk_src_sel sysclk_src_sel_chk #(
   .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .PLL_IDX(PLL_IDX), .PLL_REF_IDX(PLL_REF_IDX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata), .irq_clr(irq_clr),
   .src_en(src_en), .src_rdy(src_rdy), .sel_req(sel_req), .sel_cur(sel_cur), .irq_flag(irq_flag)
);

// File: tb/test_sysclk_src_sel.sv
module test_sysclk_src_sel;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 3;
   localparam int SW   = 2;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en_wr = 1'b0;
   logic [N-1:0]  en_wdata = '0;
   logic [N-1:0]  osc_rdy_in = '0;
   logic          sel_wr = 1'b0;
   logic [SW-1:0] sel_wdata = '0;
   logic [N-1:0]  irq_en = '0;
   logic [N-1:0]  irq_clr = '0;
   logic [N-1:0]  src_en, src_rdy, irq_flag;
   logic [SW-1:0] sel_req, sel_cur;
   logic          irq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   int dly [N] = '{3, 10, 7};
   int ocnt [N] = '{0, 0, 0};
   logic [SW-1:0] exp_q [$];
   logic [SW-1:0] last_cur = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sysclk_src_sel #(.NUM_SRC(N), .SEL_W(SW), .RDY_SYNC(SYNC)) i_sysclk_src_sel (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata), .osc_rdy_in(osc_rdy_in),
      .sel_wr(sel_wr), .sel_wdata(sel_wdata), .irq_en(irq_en), .irq_clr(irq_clr),
      .src_en(src_en), .src_rdy(src_rdy), .sel_req(sel_req), .sel_cur(sel_cur),
      .irq_flag(irq_flag), .irq(irq)
   );

   // oscillator model: ready rises a programmable number of cycles after enable
   always @(posedge clk) begin
      #1;
      for (int i = 0; i < N; i++) begin
         if (!rst_n || !src_en[i]) begin
            ocnt[i] = 0;
            osc_rdy_in[i] = 1'b0;
         end else if (ocnt[i] < dly[i]) begin
            ocnt[i]++;
         end else begin
            osc_rdy_in[i] = 1'b1;
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every change of sel_cur must match the next expected code
   always @(negedge clk) begin
      if (rst_n && sel_cur !== last_cur) begin
         if (exp_q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R3/R5 unexpected switch actual=%0d expected=%0d", sel_cur, last_cur);
         end else begin
            check("R4 switch order", 32'(sel_cur), 32'(exp_q.pop_front()));
         end
         last_cur = sel_cur;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic expect_switch(input logic [SW-1:0] code);
      exp_q.push_back(code);
   endtask

   task automatic write_en(input logic [N-1:0] v);
      @(posedge clk); #1; en_wr = 1'b1; en_wdata = v;
      @(posedge clk); #1; en_wr = 1'b0;
   endtask

   task automatic write_sel(input logic [SW-1:0] c);
      @(posedge clk); #1; sel_wr = 1'b1; sel_wdata = c;
      @(posedge clk); #1; sel_wr = 1'b0;
   endtask

   task automatic pulse_clr(input logic [N-1:0] m);
      @(posedge clk); #1; irq_clr = m;
      @(posedge clk); #1; irq_clr = '0;
   endtask

   task automatic wait_cur(input logic [SW-1:0] c, input string req);
      int n = 0;
      @(negedge clk);
      while (sel_cur !== c && n < 200) begin
         @(negedge clk);
         n++;
      end
      check(req, 32'(sel_cur), 32'(c));
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cnt;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 sel_cur", 32'(sel_cur), 0);
      check("R1 sel_req", 32'(sel_req), 0);
      check("R1 src_en", 32'(src_en), 32'b001);
      check("R1 irq_flag", 32'(irq_flag), 0);
      idle(10);
      check("R8 rc ready", 32'(src_rdy), 32'b001);

      // deferred request to a disabled source
      irq_en = 3'b111;
      write_sel(2'd1);
      idle(20);
      check("R2 sel_req", 32'(sel_req), 1);
      check("R3 still rc", 32'(sel_cur), 0);

      expect_switch(2'd1);
      write_en(3'b011);
      cnt = 0;
      while (!osc_rdy_in[1] && cnt < 100) begin
         @(negedge clk);
         cnt++;
      end
      cnt = 0;
      @(negedge clk);
      cnt++;
      while (!src_rdy[1] && cnt < 20) begin
         @(negedge clk);
         cnt++;
      end
      check("R8 sync depth", 32'(cnt), SYNC);
      check("R3 not yet switched", 32'(sel_cur), 0);
      @(negedge clk);
      check("R4 switched at next edge", 32'(sel_cur), 1);
      check("R9 irq flag xo", 32'(irq_flag[1]), 1);
      check("R9 irq out", 32'(irq), 1);
      idle(3);
      check("R9 flag sticky", 32'(irq_flag[1]), 1);
      pulse_clr(3'b010);
      @(negedge clk);
      check("R10 flag cleared", 32'(irq_flag[1]), 0);

      // protected disable of the source in use
      write_en(3'b001);
      @(negedge clk);
      check("R6 in-use kept", 32'(src_en), 32'b011);
      write_en(3'b010);
      @(negedge clk);
      check("R6 idle source off", 32'(src_en), 32'b010);
      check("R8 gated by enable", 32'(src_rdy[0]), 0);

      write_sel(2'd3);
      @(negedge clk);
      check("R2 reserved ignored", 32'(sel_req), 1);

      // replacement of a pending request
      write_sel(2'd2);
      write_sel(2'd0);
      @(negedge clk);
      check("R5 latest request", 32'(sel_req), 0);
      expect_switch(2'd0);
      write_en(3'b011);
      wait_cur(2'd0, "R5 switched to latest");
      idle(20);
      check("R5 pll never taken", 32'(sel_cur), 0);

      // PLL and its reference protection
      expect_switch(2'd2);
      write_en(3'b111);
      write_sel(2'd2);
      wait_cur(2'd2, "R4 pll selected");
      write_en(3'b001);
      @(negedge clk);
      check("R7 pll and ref kept", 32'(src_en), 32'b111);

      // immediate switch to a ready source
      expect_switch(2'd0);
      write_sel(2'd0);
      @(negedge clk);
      check("R11 sel_req", 32'(sel_req), 0);
      check("R11 sel_cur same edge", 32'(sel_cur), 0);

      // interrupt gating
      irq_en = 3'b000;
      write_en(3'b001);
      @(negedge clk);
      check("R6 released after switch", 32'(src_en), 32'b001);
      write_en(3'b011);
      idle(30);
      check("R8 xo ready again", 32'(src_rdy[1]), 1);
      check("R9 gated flag", 32'(irq_flag[1]), 0);

      idle(5);
      check("R4 queue drained", 32'(exp_q.size()), 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule